// File: doc/BRIEF.md
# MSI Private-Cache Line Coherence Controller

This block is the coherence engine for one line of a private first-level cache that takes part in a directory-based MSI protocol. It accepts three input streams: CPU operations (load, store, evict), forwarded messages from the directory (a peer read, a peer write, an invalidation, and an eviction acknowledgement), and responses (fill data and invalidation acknowledgements). It answers with coherence requests toward the directory, data and invalidation-acknowledge responses, and completion pulses for the CPU. It also holds the line's data word.

Besides the three stable states, the controller has eight transient states. These cover a miss waiting for data, an upgrade waiting for data and acknowledgements, and an eviction waiting for its acknowledgement. It resolves races where a forwarded request arrives while an upgrade or eviction is still outstanding. Acknowledgement counting is done outside the block: responses arrive already classified as complete data, data with acknowledgements still pending, an ordinary acknowledgement, or the last acknowledgement.

At most one event is consumed per cycle. If an event cannot be handled in the current state it is held back by keeping its ready low. An event that has no meaning in the current state is swallowed and raises a sticky error flag.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (invalid), `perm_o` is 0, `proto_err` is 0, and every message and completion pulse is low.
- R2: At most one of `rsp_ready`, `fwd_ready` and `cpu_ready` is high in a cycle, and a ready is high only while its valid is high. Responses win over forwards, and forwards win over CPU operations. A channel that is stalled does not block a lower channel. A response is never stalled.
- R3: A load in invalid (state 0) emits a request of kind 0 (read-shared) and enters state 1. In state 1, a response of kind 0 (complete data) stores `rsp_data`, pulses `done_load` with `rd_data` equal to it, and enters state 4 (shared).
- R4: A store in state 0 emits request kind 1 (read-exclusive) and enters state 2. A response of kind 0 then completes the store into state 7 (modified). A response of kind 1 (data, acks pending) moves state 2 to 3. Response kind 2 (ack) leaves the state alone. Response kind 3 (last ack) moves state 3 to 7 with `done_store`. The stored CPU word becomes the line data.
- R5: A load in states 4, 5, 6 or 7 pulses `done_load` with the line data and sends no message. A store in state 7 writes `cpu_wdata` and pulses `done_store`.
- R6: A store in state 4 emits request kind 1 and enters state 5. From state 5, response kind 0 completes into state 7 and response kind 1 enters state 6. An invalidation (forward kind 2) in state 5 pulses `inv_ack_out` and enters state 2.
- R7: An invalidation in state 4 pulses `inv_ack_out` and enters state 0. An invalidation in state 9 pulses `inv_ack_out` and enters state 10.
- R8: In state 7, a peer read (forward kind 0) pulses both `dat_to_req` and `dat_to_dir` with `out_data` equal to the line and enters state 4. A peer write (forward kind 1) pulses only `dat_to_req` and enters state 0.
- R9: An evict (CPU op 2) in state 4 emits request kind 2 and enters state 9. An evict in state 7 emits request kind 3 with `req_data` equal to the line and enters state 8. In state 8, a peer read sends data to both targets and enters state 9, and a peer write sends data to the requester and enters state 10. An eviction ack (forward kind 3) in states 8, 9 or 10 enters state 0.
- R10: States 1, 2, 3, 5, 6, 8, 9 and 10 stall the events listed here, holding that channel's ready low and leaving state and data untouched. State 1 stalls CPU ops and invalidations. States 2 and 3 stall CPU ops and peer reads and writes. States 5 and 6 stall stores, evicts and peer reads and writes. States 8, 9 and 10 stall CPU ops.
- R11: An event with no defined transition in the current state is consumed, leaves state and data unchanged, and sets `proto_err`, which stays high until reset.
- R12: `perm_o` is 2 (read-write) in state 7; 1 (read-only) in states 4, 5 and 6; 3 (busy) in states 3, 8 and 9; and 0 otherwise. CPU op codes are 0 load, 1 store, 2 evict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU operation present |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | CPU operation consumed this cycle |
| fwd_valid | input | 1 | Forwarded message present |
| fwd_kind | input | 2 | 0 peer read, 1 peer write, 2 invalidate, 3 eviction ack |
| fwd_ready | output | 1 | Forwarded message consumed |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 0 complete data, 1 data with acks pending, 2 ack, 3 last ack |
| rsp_data | input | DW | Fill data |
| rsp_ready | output | 1 | Response consumed |
| req_valid | output | 1 | Request pulse to directory |
| req_kind | output | 2 | 0 read-shared, 1 read-exclusive, 2 clean evict, 3 dirty evict |
| req_data | output | DW | Line data with dirty evict |
| dat_to_req | output | 1 | Data response pulse to requester |
| dat_to_dir | output | 1 | Data response pulse to directory |
| inv_ack_out | output | 1 | Invalidation-ack pulse |
| out_data | output | DW | Data carried by data responses |
| done_load | output | 1 | Load completion pulse |
| done_store | output | 1 | Store completion pulse |
| rd_data | output | DW | Load result |
| state_o | output | 4 | Current line state code |
| perm_o | output | 2 | Access permission code |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that a valid input is held with a stable kind until its ready rises. They also assume that responses reach the block only while a transaction of its own is outstanding, so a response is never something the block has to stall. The stimulus raises every valid at a falling edge, keeps it through exactly one rising edge, and drops it afterwards whether or not it was taken. Stalled operations are therefore presented for one cycle and then withdrawn. Undefined events are sent only in the one scenario aimed at the error flag.

// File: rtl/msi_pkg.sv
package msi_pkg;

   typedef enum logic [3:0] {
      ST_INV    = 4'd0,
      ST_I2S    = 4'd1,
      ST_I2M_AD = 4'd2,
      ST_I2M_A  = 4'd3,
      ST_SHD    = 4'd4,
      ST_S2M_AD = 4'd5,
      ST_S2M_A  = 4'd6,
      ST_MOD    = 4'd7,
      ST_M2I    = 4'd8,
      ST_S2I    = 4'd9,
      ST_I2I    = 4'd10
   } lstate_t;

   // event code = {channel, kind}; channel 0 cpu, 1 forward, 2 response
   typedef enum logic [3:0] {
      EV_LOAD      = 4'd0,
      EV_STORE     = 4'd1,
      EV_EVICT     = 4'd2,
      EV_CPU_BAD   = 4'd3,
      EV_PEER_RD   = 4'd4,
      EV_PEER_WR   = 4'd5,
      EV_INVAL     = 4'd6,
      EV_EVICT_ACK = 4'd7,
      EV_DATA_FULL = 4'd8,
      EV_DATA_WAIT = 4'd9,
      EV_ACK       = 4'd10,
      EV_ACK_LAST  = 4'd11
   } ev_t;

   typedef enum logic [1:0] {
      RQ_RD_SHR  = 2'd0,
      RQ_RD_EXCL = 2'd1,
      RQ_EV_CLN  = 2'd2,
      RQ_EV_DRT  = 2'd3
   } rq_t;

   typedef enum logic [1:0] {
      PM_NONE = 2'd0,
      PM_RO   = 2'd1,
      PM_RW   = 2'd2,
      PM_BUSY = 2'd3
   } perm_t;

   typedef struct packed {
      logic    stall;
      logic    err;
      lstate_t nxt;
      logic    req;
      rq_t     rq;
      logic    dat_req;
      logic    dat_dir;
      logic    inv_ack;
      logic    ld_hit;
      logic    ld_fill;
      logic    st_hit;
      logic    st_commit;
      logic    cap_st;
      logic    fill;
   } act_t;

   function automatic perm_t perm_of(lstate_t s);
      case (s)
         ST_MOD:                      return PM_RW;
         ST_SHD, ST_S2M_AD, ST_S2M_A: return PM_RO;
         ST_I2M_A, ST_M2I, ST_S2I:    return PM_BUSY;
         default:                     return PM_NONE;
      endcase
   endfunction

endpackage

// File: rtl/msi_xition.sv
module msi_xition
   import msi_pkg::*;
(
   input  lstate_t cur,
   input  ev_t     ev,
   output act_t    act
);

   logic is_cpu;
   assign is_cpu = (ev == EV_LOAD) || (ev == EV_STORE) || (ev == EV_EVICT);

   always_comb begin
      act     = '0;
      act.nxt = cur;
      case (cur)
         ST_INV: begin
            case (ev)
               EV_LOAD:  begin act.nxt = ST_I2S;    act.req = 1'b1; act.rq = RQ_RD_SHR; end
               EV_STORE: begin act.nxt = ST_I2M_AD; act.req = 1'b1; act.rq = RQ_RD_EXCL; act.cap_st = 1'b1; end
               default:  act.err = 1'b1;
            endcase
         end
         ST_I2S: begin
            if (is_cpu || ev == EV_INVAL) act.stall = 1'b1;
            else if (ev == EV_DATA_FULL) begin
               act.nxt = ST_SHD; act.ld_fill = 1'b1;
            end
            else act.err = 1'b1;
         end
         ST_I2M_AD, ST_I2M_A: begin
            if (is_cpu || ev == EV_PEER_RD || ev == EV_PEER_WR) act.stall = 1'b1;
            else if (ev == EV_ACK) act.nxt = cur;
            else if (cur == ST_I2M_AD && ev == EV_DATA_FULL) begin
               act.nxt = ST_MOD; act.st_commit = 1'b1;
            end
            else if (cur == ST_I2M_AD && ev == EV_DATA_WAIT) begin
               act.nxt = ST_I2M_A; act.fill = 1'b1;
            end
            else if (cur == ST_I2M_A && ev == EV_ACK_LAST) begin
               act.nxt = ST_MOD; act.st_commit = 1'b1;
            end
            else act.err = 1'b1;
         end
         ST_SHD: begin
            case (ev)
               EV_LOAD:  act.ld_hit = 1'b1;
               EV_STORE: begin act.nxt = ST_S2M_AD; act.req = 1'b1; act.rq = RQ_RD_EXCL; act.cap_st = 1'b1; end
               EV_EVICT: begin act.nxt = ST_S2I;    act.req = 1'b1; act.rq = RQ_EV_CLN; end
               EV_INVAL: begin act.nxt = ST_INV;    act.inv_ack = 1'b1; end
               default:  act.err = 1'b1;
            endcase
         end
         ST_S2M_AD, ST_S2M_A: begin
            if (ev == EV_STORE || ev == EV_EVICT || ev == EV_PEER_RD || ev == EV_PEER_WR)
               act.stall = 1'b1;
            else if (ev == EV_LOAD) act.ld_hit = 1'b1;
            else if (ev == EV_ACK) act.nxt = cur;
            else if (cur == ST_S2M_AD && ev == EV_INVAL) begin
               act.nxt = ST_I2M_AD; act.inv_ack = 1'b1;
            end
            else if (cur == ST_S2M_AD && ev == EV_DATA_FULL) begin
               act.nxt = ST_MOD; act.st_commit = 1'b1;
            end
            else if (cur == ST_S2M_AD && ev == EV_DATA_WAIT) begin
               act.nxt = ST_S2M_A; act.fill = 1'b1;
            end
            else if (cur == ST_S2M_A && ev == EV_ACK_LAST) begin
               act.nxt = ST_MOD; act.st_commit = 1'b1;
            end
            else act.err = 1'b1;
         end
         ST_MOD: begin
            case (ev)
               EV_LOAD:    act.ld_hit = 1'b1;
               EV_STORE:   act.st_hit = 1'b1;
               EV_EVICT:   begin act.nxt = ST_M2I; act.req = 1'b1; act.rq = RQ_EV_DRT; end
               EV_PEER_RD: begin act.nxt = ST_SHD; act.dat_req = 1'b1; act.dat_dir = 1'b1; end
               EV_PEER_WR: begin act.nxt = ST_INV; act.dat_req = 1'b1; end
               default:    act.err = 1'b1;
            endcase
         end
         ST_M2I, ST_S2I, ST_I2I: begin
            if (is_cpu) act.stall = 1'b1;
            else if (ev == EV_EVICT_ACK) act.nxt = ST_INV;
            else if (cur == ST_M2I && ev == EV_PEER_RD) begin
               act.nxt = ST_S2I; act.dat_req = 1'b1; act.dat_dir = 1'b1;
            end
            else if (cur == ST_M2I && ev == EV_PEER_WR) begin
               act.nxt = ST_I2I; act.dat_req = 1'b1;
            end
            else if (cur == ST_S2I && ev == EV_INVAL) begin
               act.nxt = ST_I2I; act.inv_ack = 1'b1;
            end
            else act.err = 1'b1;
         end
         default: act.err = 1'b1;
      endcase
   end

endmodule

// File: rtl/msi_chan_pick.sv
module msi_chan_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] valid,
   input  logic [N-1:0] stall,
   output logic [N-1:0] grant
);

   generate
      if (N < 1) begin : g_bad_n
         $error("msi_chan_pick: N must be at least 1");
      end
   endgenerate

   // index 0 has the highest priority
   always_comb begin
      logic found;
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!found && valid[i] && !stall[i]) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
   import msi_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_valid,
   input  logic [1:0]    cpu_op,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   input  logic          fwd_valid,
   input  logic [1:0]    fwd_kind,
   output logic          fwd_ready,
   input  logic          rsp_valid,
   input  logic [1:0]    rsp_kind,
   input  logic [DW-1:0] rsp_data,
   output logic          rsp_ready,
   output logic          req_valid,
   output logic [1:0]    req_kind,
   output logic [DW-1:0] req_data,
   output logic          dat_to_req,
   output logic          dat_to_dir,
   output logic          inv_ack_out,
   output logic [DW-1:0] out_data,
   output logic          done_load,
   output logic          done_store,
   output logic [DW-1:0] rd_data,
   output logic [3:0]    state_o,
   output logic [1:0]    perm_o,
   output logic          proto_err
);

   localparam int NCH = 3;

   generate
      if (DW < 1 || DW > 1024) begin : g_bad_dw
         $error("msi_line_ctrl: DW must lie in 1..1024");
      end
   endgenerate

   lstate_t       state_q;
   logic [DW-1:0] line_q;
   logic [DW-1:0] pend_q;
   logic          err_q;

   logic [1:0]     kind_a [NCH];
   logic [NCH-1:0] vld_a;
   logic [NCH-1:0] stl_a;
   logic [NCH-1:0] gnt;
   act_t           act_a [NCH];
   act_t           sel;

   // slot 0 responses, slot 1 forwards, slot 2 cpu (priority order)
   assign kind_a[0] = rsp_kind;
   assign kind_a[1] = fwd_kind;
   assign kind_a[2] = cpu_op;
   assign vld_a     = {cpu_valid, fwd_valid, rsp_valid};

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         localparam logic [1:0] CH = (g == 0) ? 2'd2 : (g == 1) ? 2'd1 : 2'd0;
         ev_t ev;
         assign ev = ev_t'({CH, kind_a[g]});
         msi_xition u_x (
            .cur (state_q),
            .ev  (ev),
            .act (act_a[g])
         );
         assign stl_a[g] = act_a[g].stall;
      end
   endgenerate

   msi_chan_pick #(.N(NCH)) u_pick (
      .valid (vld_a),
      .stall (stl_a),
      .grant (gnt)
   );

   assign rsp_ready = gnt[0];
   assign fwd_ready = gnt[1];
   assign cpu_ready = gnt[2];

   always_comb begin
      sel = '0;
      sel.nxt = state_q;
      for (int i = 0; i < NCH; i++) begin
         if (gnt[i]) sel = act_a[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_INV;
         line_q      <= '0;
         pend_q      <= '0;
         err_q       <= 1'b0;
         req_valid   <= 1'b0;
         req_kind    <= 2'd0;
         req_data    <= '0;
         dat_to_req  <= 1'b0;
         dat_to_dir  <= 1'b0;
         inv_ack_out <= 1'b0;
         out_data    <= '0;
         done_load   <= 1'b0;
         done_store  <= 1'b0;
         rd_data     <= '0;
      end else begin
         req_valid   <= 1'b0;
         dat_to_req  <= 1'b0;
         dat_to_dir  <= 1'b0;
         inv_ack_out <= 1'b0;
         done_load   <= 1'b0;
         done_store  <= 1'b0;
         if (|gnt) begin
            if (sel.err) begin
               err_q <= 1'b1;
            end else begin
               state_q <= sel.nxt;
               if (sel.cap_st)    pend_q <= cpu_wdata;
               if (sel.fill || sel.ld_fill) line_q <= rsp_data;
               if (sel.st_hit)    line_q <= cpu_wdata;
               if (sel.st_commit) line_q <= pend_q;
               if (sel.req) begin
                  req_valid <= 1'b1;
                  req_kind  <= sel.rq;
                  req_data  <= line_q;
               end
               if (sel.dat_req || sel.dat_dir) out_data <= line_q;
               dat_to_req  <= sel.dat_req;
               dat_to_dir  <= sel.dat_dir;
               inv_ack_out <= sel.inv_ack;
               if (sel.ld_hit || sel.ld_fill) begin
                  done_load <= 1'b1;
                  rd_data   <= sel.ld_fill ? rsp_data : line_q;
               end
               done_store <= sel.st_hit || sel.st_commit;
            end
         end
      end
   end

   assign state_o   = state_q;
   assign perm_o    = perm_of(state_q);
   assign proto_err = err_q;

endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic       cpu_ready,
   input logic       fwd_valid,
   input logic [1:0] fwd_kind,
   input logic       fwd_ready,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic       req_valid,
   input logic [1:0] req_kind,
   input logic       done_load,
   input logic       done_store,
   input logic [3:0] state_o,
   input logic [1:0] perm_o,
   input logic       proto_err
);

   assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_ready, fwd_ready, rsp_ready}));

   assert_ready_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready -> cpu_valid) && (fwd_ready -> fwd_valid) && (rsp_ready -> rsp_valid));

   assert_rsp_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_ready);

   assert_evict_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o inside {4'd8, 4'd9, 4'd10}) |-> !cpu_ready);

   assert_fwd_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o inside {4'd2, 4'd3, 4'd5, 4'd6}) && fwd_valid && fwd_kind <= 2'd1) |-> !fwd_ready);

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ready && !fwd_ready && !rsp_ready) |=> $stable(state_o));

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   assert_store_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_store |-> state_o == 4'd7);

   assert_load_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_load |-> (perm_o == 2'd1 || perm_o == 2'd2));

   assert_dirty_evict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3) |-> state_o == 4'd8);

endmodule

bind msi_line_ctrl msi_line_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_ready  (cpu_ready),
   .fwd_valid  (fwd_valid),
   .fwd_kind   (fwd_kind),
   .fwd_ready  (fwd_ready),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .req_valid  (req_valid),
   .req_kind   (req_kind),
   .done_load  (done_load),
   .done_store (done_store),
   .state_o    (state_o),
   .perm_o     (perm_o),
   .proto_err  (proto_err)
);

// File: tb/msi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_line_ctrl_tb_top;

   localparam int DW = 32;
   localparam logic [1:0] LD = 2'd0, STR = 2'd1, EVC = 2'd2;
   localparam logic [1:0] PRD = 2'd0, PWR = 2'd1, INV = 2'd2, PAK = 2'd3;
   localparam logic [1:0] DFULL = 2'd0, DWAIT = 2'd1, ACK = 2'd2, ALAST = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [1:0]    cpu_op = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic          fwd_valid = 1'b0;
   logic [1:0]    fwd_kind = '0;
   logic          fwd_ready;
   logic          rsp_valid = 1'b0;
   logic [1:0]    rsp_kind = '0;
   logic [DW-1:0] rsp_data = '0;
   logic          rsp_ready;
   logic          req_valid;
   logic [1:0]    req_kind;
   logic [DW-1:0] req_data;
   logic          dat_to_req, dat_to_dir, inv_ack_out;
   logic [DW-1:0] out_data;
   logic          done_load, done_store;
   logic [DW-1:0] rd_data;
   logic [3:0]    state_o;
   logic [1:0]    perm_o;
   logic          proto_err;

   int n_total = 0;
   int n_bad   = 0;
   logic cr, fr, rr;

   always #2 clk = ~clk;

   msi_line_ctrl #(.DW(DW)) dut_i (.*);

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // drive at a falling edge, hold through one rising edge, outputs visible at the next falling edge
   task automatic step(input logic cv, input logic [1:0] cop, input logic [DW-1:0] cw,
                       input logic fv, input logic [1:0] fk,
                       input logic rv, input logic [1:0] rk, input logic [DW-1:0] rd);
      cpu_valid = cv; cpu_op = cop; cpu_wdata = cw;
      fwd_valid = fv; fwd_kind = fk;
      rsp_valid = rv; rsp_kind = rk; rsp_data = rd;
      #1;
      cr = cpu_ready; fr = fwd_ready; rr = rsp_ready;
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0; fwd_valid = 1'b0; rsp_valid = 1'b0;
   endtask

   task automatic cpu(input logic [1:0] op, input logic [DW-1:0] w);
      step(1'b1, op, w, 1'b0, 2'd0, 1'b0, 2'd0, '0);
   endtask
   task automatic fwd(input logic [1:0] k);
      step(1'b0, 2'd0, '0, 1'b1, k, 1'b0, 2'd0, '0);
   endtask
   task automatic rsp(input logic [1:0] k, input logic [DW-1:0] d);
      step(1'b0, 2'd0, '0, 1'b0, 2'd0, 1'b1, k, d);
   endtask

   task automatic t_reset;
      chk("R1", "state", state_o, 0);
      chk("R1", "perm", perm_o, 0);
      chk("R1", "err", proto_err, 0);
      chk("R1", "pulses", {req_valid, dat_to_req, dat_to_dir, inv_ack_out, done_load, done_store}, 0);
   endtask

   task automatic t_load_miss;
      cpu(LD, '0);
      chk("R3", "ready", cr, 1);
      chk("R3", "req", {req_valid, req_kind}, {1'b1, 2'd0});
      chk("R3", "state", state_o, 1);
      rsp(DFULL, 32'hA5A5_0001);
      chk("R3", "fill done", {done_load, rd_data}, {1'b1, 32'hA5A5_0001});
      chk("R3", "state", state_o, 4);
      chk("R12", "perm S", perm_o, 1);
      cpu(LD, '0);
      chk("R5", "hit", {done_load, rd_data, req_valid}, {1'b1, 32'hA5A5_0001, 1'b0});
      fwd(INV);
      chk("R7", "inv in S", {inv_ack_out, state_o}, {1'b1, 4'd0});
   endtask

   task automatic t_store_miss;
      cpu(STR, 32'h1111_2222);
      chk("R4", "getm", {req_valid, req_kind, state_o}, {1'b1, 2'd1, 4'd2});
      rsp(DWAIT, 32'hDEAD_0000);
      chk("R4", "wait acks", state_o, 3);
      chk("R12", "perm busy", perm_o, 3);
      rsp(ACK, '0);
      chk("R4", "ack stays", {state_o, done_store}, {4'd3, 1'b0});
      cpu(LD, '0);
      chk("R10", "load stalled", {cr, state_o, done_load}, {1'b0, 4'd3, 1'b0});
      fwd(PRD);
      chk("R10", "peer rd stalled", {fr, state_o}, {1'b0, 4'd3});
      rsp(ALAST, '0);
      chk("R4", "last ack", {done_store, state_o}, {1'b1, 4'd7});
      chk("R12", "perm M", perm_o, 2);
      cpu(LD, '0);
      chk("R4", "store data", rd_data, 32'h1111_2222);
   endtask

   task automatic t_m_peer_rd;
      cpu(STR, 32'h3333_4444);
      chk("R5", "store hit", {done_store, req_valid, state_o}, {1'b1, 1'b0, 4'd7});
      fwd(PRD);
      chk("R8", "peer rd", {dat_to_req, dat_to_dir, out_data, state_o},
          {1'b1, 1'b1, 32'h3333_4444, 4'd4});
   endtask

   task automatic t_upgrade;
      cpu(STR, 32'h5555_6666);
      chk("R6", "upgrade", {req_valid, req_kind, state_o}, {1'b1, 2'd1, 4'd5});
      cpu(LD, '0);
      chk("R5", "hit in upgrade", {done_load, rd_data}, {1'b1, 32'h3333_4444});
      cpu(STR, 32'h9999_9999);
      chk("R10", "store stalled", {cr, state_o}, {1'b0, 4'd5});
      fwd(INV);
      chk("R6", "inv during upgrade", {inv_ack_out, state_o}, {1'b1, 4'd2});
      rsp(DFULL, 32'h0BAD_0BAD);
      chk("R6", "complete", {done_store, state_o}, {1'b1, 4'd7});
      cpu(LD, '0);
      chk("R6", "data kept", rd_data, 32'h5555_6666);
      fwd(PWR);
      chk("R8", "peer wr", {dat_to_req, dat_to_dir, out_data, state_o},
          {1'b1, 1'b0, 32'h5555_6666, 4'd0});
   endtask

   task automatic t_evict_races;
      cpu(STR, 32'h7777_0000);
      rsp(DFULL, '0);
      cpu(EVC, '0);
      chk("R9", "dirty evict", {req_valid, req_kind, req_data, state_o},
          {1'b1, 2'd3, 32'h7777_0000, 4'd8});
      cpu(LD, '0);
      chk("R10", "cpu stalled evicting", {cr, state_o}, {1'b0, 4'd8});
      fwd(PRD);
      chk("R9", "peer rd in evict", {dat_to_req, dat_to_dir, state_o}, {1'b1, 1'b1, 4'd9});
      fwd(INV);
      chk("R7", "inv in clean evict", {inv_ack_out, state_o, perm_o}, {1'b1, 4'd10, 2'd0});
      fwd(PAK);
      chk("R9", "evict ack", state_o, 0);
      cpu(LD, '0);
      rsp(DFULL, 32'hC0C0_C0C0);
      cpu(EVC, '0);
      chk("R9", "clean evict", {req_valid, req_kind, state_o}, {1'b1, 2'd2, 4'd9});
      fwd(PAK);
      chk("R9", "ack from clean", state_o, 0);
      cpu(STR, 32'h8888_0000);
      rsp(DFULL, '0);
      cpu(EVC, '0);
      fwd(PWR);
      chk("R9", "peer wr in evict", {dat_to_req, dat_to_dir, out_data, state_o},
          {1'b1, 1'b0, 32'h8888_0000, 4'd10});
      fwd(PAK);
      chk("R9", "ack from II", state_o, 0);
   endtask

   task automatic t_priority;
      cpu(LD, '0);
      rsp(DFULL, 32'h0000_00D0);
      step(1'b1, LD, '0, 1'b1, INV, 1'b0, 2'd0, '0);
      chk("R2", "fwd over cpu", {fr, cr, inv_ack_out, done_load, state_o},
          {1'b1, 1'b0, 1'b1, 1'b0, 4'd0});
      cpu(LD, '0);
      step(1'b1, LD, '0, 1'b1, INV, 1'b1, DFULL, 32'h0000_00E0);
      chk("R2", "rsp over all", {rr, fr, cr}, {1'b1, 1'b0, 1'b0});
      chk("R2", "rsp result", {done_load, rd_data, state_o}, {1'b1, 32'h0000_00E0, 4'd4});
      cpu(STR, 32'h6666_0006);
      step(1'b1, STR, 32'h1, 1'b1, PRD, 1'b1, ACK, '0);
      chk("R2", "ack taken", {rr, state_o}, {1'b1, 4'd5});
      step(1'b1, STR, 32'h1, 1'b1, INV, 1'b0, 2'd0, '0);
      chk("R2", "stalled cpu no block", {fr, cr, state_o}, {1'b1, 1'b0, 4'd2});
      rsp(DFULL, '0);
      cpu(LD, '0);
      chk("R2", "pending store", {done_load, rd_data}, {1'b1, 32'h6666_0006});
   endtask

   task automatic t_error;
      fwd(PAK);
      chk("R11", "consumed", {fr, state_o}, {1'b1, 4'd7});
      chk("R11", "flag", proto_err, 1);
      cpu(LD, '0);
      chk("R11", "sticky + data intact", {proto_err, rd_data}, {1'b1, 32'h6666_0006});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_miss();
      t_store_miss();
      t_m_peer_rd();
      t_upgrade();
      t_evict_races();
      t_priority();
      t_error();
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule